// File: doc/BRIEF.md
# Nibble-Coded NRZI Line Transmitter

This block sits between a first-word-fall-through character queue and a serial line. It draws one character per character period, turns it into a 10-bit transmission character and shifts that character onto the line one bit per bit clock, highest bit first. The line is driven with NRZI signalling: every 1 bit flips the line and every 0 bit leaves it where it was.

There are three kinds of character. A data byte is coded one nibble at a time with the standard 4B/5B data code, high nibble first. A command code (0 to 3) becomes a symbol pair drawn from the 4B/5B control symbols, which never occur in data. When the encoder bypass is set, the ten queue bits go out unchanged and the command flag is ignored. When the queue is empty at a character boundary, the block sends the J/K sync pair so that the receiver keeps its framing.

A 10-state bit counter sets the character period. The queue is popped on the last bit of a character, and the new character is loaded at the same clock edge.

Top module: `enc4b5b_nrzi_tx`

## Requirements
- R1: While reset is high, tx_line is 0 and fifo_pop is 0. The first character sent after reset is the sync pair 1100010001.
- R2: When fifo_is_cmd is 0 and bypass is 0, the data byte in fifo_word[7:0] is sent as {code(fifo_word[7:4]), code(fifo_word[3:0])}. The code table for nibbles 0 to F is 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Each character is sent bit 9 first.
- R3: When fifo_is_cmd is 1 and bypass is 0, only fifo_word[1:0] is used. It selects 0→1111111111, 1→0110100111, 2→0110111001, 3→0010000100.
- R4: When bypass is 1, fifo_word[9:0] is sent unchanged and fifo_is_cmd has no effect.
- R5: When fifo_empty is 1 at a character boundary, the sync pair 1100010001 is sent and fifo_pop stays 0.
- R6: Every serial 1 bit inverts tx_line at the next clock edge, and every 0 bit leaves it unchanged.
- R7: Each character lasts exactly 10 clocks. fifo_pop can be 1 only in the 10th clock of a character (clock 9, 19, 29, … after reset is released), and it is 1 there whenever fifo_empty is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | Queue has no character |
| fifo_is_cmd | input | 1 | Head character is a command code |
| fifo_word | input | 10 | Head character: data byte, command code or raw 10-bit word |
| bypass | input | 1 | Send fifo_word unchanged |
| fifo_pop | output | 1 | Consume the head character at this edge |
| tx_line | output | 1 | NRZI serial line |

## Verification
The hardest thing to reach from the ports is a character boundary where the queue is empty while the inputs carry data, because the sync pair must win over whatever fifo_word holds. The stimulus list therefore places empty slots between data, command and raw characters, and keeps a nonzero word on the bus during those slots. The bench recovers the serial bits by undoing NRZI at the line. It then compares each 10-bit frame against a character it computes itself, and it also checks the pop strobe on every clock.

// File: rtl/enc4b5b_pkg.sv
package enc4b5b_pkg;
  localparam int SYM_W  = 5;
  localparam int NIB_W  = 4;

  localparam logic [SYM_W-1:0] SYM_J = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_S = 5'b11001;
  localparam logic [SYM_W-1:0] SYM_H = 5'b00100;
  localparam logic [SYM_W-1:0] SYM_I = 5'b11111;

  localparam logic [2*SYM_W-1:0] SYNC_PAIR = {SYM_J, SYM_K};

  function automatic logic [SYM_W-1:0] nib_code(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  function automatic logic [2*SYM_W-1:0] cmd_pair(input logic [1:0] c);
    logic [2*SYM_W-1:0] p;
    case (c)
      2'd0: p = {SYM_I, SYM_I};
      2'd1: p = {SYM_T, SYM_R};
      2'd2: p = {SYM_T, SYM_S};
      default: p = {SYM_H, SYM_H};
    endcase
    return p;
  endfunction
endpackage

// File: rtl/enc4b5b_char_map.sv
module enc4b5b_char_map
  import enc4b5b_pkg::*;
#(
  parameter int CHAR_W = 10
) (
  input  logic              idle,
  input  logic              is_cmd,
  input  logic              bypass,
  input  logic [CHAR_W-1:0] word,
  output logic [CHAR_W-1:0] chr
);
  localparam int NIBS = CHAR_W / SYM_W;

  logic [CHAR_W-1:0] data_chr;

  genvar g;
  generate
    for (g = 0; g < NIBS; g++) begin : g_nib
      assign data_chr[g*SYM_W +: SYM_W] = nib_code(word[g*NIB_W +: NIB_W]);
    end
  endgenerate

  always_comb begin
    if (idle)        chr = SYNC_PAIR;
    else if (bypass) chr = word;
    else if (is_cmd) chr = cmd_pair(word[1:0]);
    else             chr = data_chr;
  end
endmodule

// File: rtl/enc4b5b_shifter.sv
module enc4b5b_shifter
  import enc4b5b_pkg::*;
#(
  parameter int CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] next_chr,
  output logic              cur_bit,
  output logic              last_bit
);
  localparam int CNT_W = $clog2(CHAR_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHAR_W - 1);

  logic [CNT_W-1:0]  cnt;
  logic [CHAR_W-1:0] sh;

  assign last_bit = (cnt == CNT_LAST);
  assign cur_bit  = sh[CHAR_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sh  <= SYNC_PAIR;
    end else if (last_bit) begin
      cnt <= '0;
      sh  <= next_chr;
    end else begin
      cnt <= cnt + 1'b1;
      sh  <= {sh[CHAR_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/enc4b5b_nrzi.sv
module enc4b5b_nrzi (
  input  logic clk,
  input  logic rst,
  input  logic nrz_bit,
  output logic line
);
  always_ff @(posedge clk) begin
    if (rst) line <= 1'b0;
    else     line <= line ^ nrz_bit;
  end
endmodule

// File: rtl/enc4b5b_nrzi_tx.sv
module enc4b5b_nrzi_tx #(
  parameter int CHAR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_empty,
  input  logic              fifo_is_cmd,
  input  logic [CHAR_W-1:0] fifo_word,
  input  logic              bypass,
  output logic              fifo_pop,
  output logic              tx_line
);
  logic [CHAR_W-1:0] next_chr;
  logic              cur_bit;
  logic              last_bit;

  enc4b5b_char_map #(.CHAR_W(CHAR_W)) u_map (
    .idle   (fifo_empty),
    .is_cmd (fifo_is_cmd),
    .bypass (bypass),
    .word   (fifo_word),
    .chr    (next_chr)
  );

  enc4b5b_shifter #(.CHAR_W(CHAR_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .next_chr (next_chr),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  enc4b5b_nrzi u_line (
    .clk     (clk),
    .rst     (rst),
    .nrz_bit (cur_bit),
    .line    (tx_line)
  );

  assign fifo_pop = last_bit & ~fifo_empty;
endmodule

// File: rtl/enc4b5b_nrzi_chk.sv
module enc4b5b_nrzi_chk #(
  parameter int CHAR_W = 10
) (
  input logic clk,
  input logic rst,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic tx_line,
  input logic cur_bit
);
  localparam int PH_W = $clog2(CHAR_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CHAR_W - 1);

  logic [PH_W-1:0] phase;
  logic            armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      armed <= 1'b0;
    end else begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      armed <= 1'b1;
    end
  end

  a_r1_line_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (tx_line == 1'b0));

  a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !fifo_pop);

  a_r7_pop_on_boundary: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (phase == PH_LAST));

  a_r7_pop_when_ready: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LAST && !fifo_empty) |-> fifo_pop);

  a_r6_nrzi_rule: assert property (@(posedge clk) disable iff (rst)
    armed |-> (tx_line == ($past(tx_line) ^ $past(cur_bit))));
endmodule

bind enc4b5b_nrzi_tx enc4b5b_nrzi_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .tx_line    (tx_line),
  .cur_bit    (cur_bit)
);

// File: tb/sim_enc4b5b_nrzi_tx.sv
module sim_enc4b5b_nrzi_tx;
  localparam int MAXI = 400;
  localparam logic [9:0] JK = 10'b1100010001;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst;
  logic       fifo_empty;
  logic       fifo_is_cmd;
  logic [9:0] fifo_word;
  logic       bypass;
  logic       fifo_pop;
  logic       tx_line;

  enc4b5b_nrzi_tx u0 (
    .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_is_cmd(fifo_is_cmd),
    .fifo_word(fifo_word), .bypass(bypass), .fifo_pop(fifo_pop), .tx_line(tx_line)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic       it_hole [MAXI];
  logic       it_byp  [MAXI];
  logic       it_cmd  [MAXI];
  logic [9:0] it_word [MAXI];
  int ni = 0;

  logic [9:0] expq[$];
  int         tagq[$];

  function automatic logic [4:0] code(input logic [3:0] n);
    logic [4:0] s;
    case (n)
      4'h0: s = 5'b11110; 4'h1: s = 5'b01001; 4'h2: s = 5'b10100; 4'h3: s = 5'b10101;
      4'h4: s = 5'b01010; 4'h5: s = 5'b01011; 4'h6: s = 5'b01110; 4'h7: s = 5'b01111;
      4'h8: s = 5'b10010; 4'h9: s = 5'b10011; 4'hA: s = 5'b10110; 4'hB: s = 5'b10111;
      4'hC: s = 5'b11010; 4'hD: s = 5'b11011; 4'hE: s = 5'b11100; default: s = 5'b11101;
    endcase
    return s;
  endfunction

  function automatic logic [9:0] cmd_exp(input logic [1:0] c);
    case (c)
      2'd0: return 10'b1111111111;
      2'd1: return 10'b0110100111;
      2'd2: return 10'b0110111001;
      default: return 10'b0010000100;
    endcase
  endfunction

  task automatic check(input bit ok, input int req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%b expected=%b", req, act[9:0], exp[9:0]);
    end
  endtask

  task automatic add(input logic h, input logic b, input logic c, input logic [9:0] w);
    it_hole[ni] = h; it_byp[ni] = b; it_cmd[ni] = c; it_word[ni] = w;
    ni++;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R7 watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int n, rd, bc, extra;
    bit pending, empty_now, bitv;
    logic prevline;
    logic [9:0] rx;

    // stimulus list: all bytes (R2), commands (R3), raw words (R4), holes (R5)
    for (int d = 0; d < 256; d++) begin
      add(1'b0, 1'b0, 1'b0, {2'b11, d[7:0]});
      if (d % 17 == 5) add(1'b1, 1'b0, 1'b0, 10'h3A5);
    end
    for (int c = 0; c < 4; c++) begin
      add(1'b0, 1'b0, 1'b1, {8'hB6, c[1:0]});
      add(1'b1, 1'b1, 1'b1, 10'h155);
    end
    add(1'b0, 1'b1, 1'b1, 10'h000);
    add(1'b0, 1'b1, 1'b0, 10'h3FF);
    for (int i = 0; i < 48; i++) begin
      int w;
      w = (i * 149 + 37) % 1024;
      add(1'b0, 1'b1, i[0], w[9:0]);
    end

    rst = 1'b1; fifo_empty = 1'b1; fifo_is_cmd = 1'b0; fifo_word = '0; bypass = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_line == 1'b0, 1, int'(tx_line), 0);   // R1 line low in reset
    check(fifo_pop == 1'b0, 1, int'(fifo_pop), 0); // R1 no pop in reset
    rst = 1'b0;
    n = 0; rd = 0; bc = 0; pending = 0; prevline = 1'b0; rx = '0; extra = 0;
    expq.push_back(JK); tagq.push_back(1);
    empty_now = (rd >= ni) || it_hole[rd];
    fifo_empty = empty_now; fifo_is_cmd = it_cmd[rd]; fifo_word = it_word[rd]; bypass = it_byp[rd];

    while (extra < 3) begin
      @(negedge clk);
      n++;
      if (n == 1) check(tx_line == 1'b1, 6, int'(tx_line), 1); // R6 first 1 bit flips line
      bitv = tx_line ^ prevline;
      prevline = tx_line;
      rx = {rx[8:0], bitv};
      bc++;
      if (bc == 10) begin
        logic [9:0] e;
        int t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(rx == e, t, int'(rx), int'(e)); // R6 decode + R1..R5 frame content
        bc = 0;
      end
      if (pending) begin rd++; pending = 0; end
      if (rd < ni) begin
        empty_now = it_hole[rd];
        fifo_is_cmd = it_cmd[rd]; fifo_word = it_word[rd]; bypass = it_byp[rd];
      end else begin
        empty_now = 1'b1;
        fifo_is_cmd = 1'b0; fifo_word = 10'h2C3; bypass = 1'b0;
      end
      fifo_empty = empty_now;
      #1;
      // R7 pop only on the last bit of a character, and whenever not empty there
      check(fifo_pop == ((n % 10 == 9) && !empty_now), 7, int'(fifo_pop),
            int'((n % 10 == 9) && !empty_now));
      if (n % 10 == 9) begin
        if (empty_now) begin
          expq.push_back(JK); tagq.push_back(5);
        end else if (it_byp[rd]) begin
          expq.push_back(it_word[rd]); tagq.push_back(4);
        end else if (it_cmd[rd]) begin
          expq.push_back(cmd_exp(it_word[rd][1:0])); tagq.push_back(3);
        end else begin
          expq.push_back({code(it_word[rd][7:4]), code(it_word[rd][3:0])}); tagq.push_back(2);
        end
        if (rd < ni) pending = 1;
        else extra++;
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule